// File: doc/BRIEF.md
# Byte-Lane Write Controller for Whole-Word Memory

This block places a 32-bit request port in front of a 256-word storage array that can only ever be written a full word at a time. Reads and full-word writes go to the array directly. A write that enables only some of its four byte lanes becomes a short read-merge-write sequence. The controller fetches the stored word and keeps the lanes that are not enabled. It replaces the enabled lanes with the new data, then writes the complete word back.

The requester raises `reqRd` or `reqWr` together with the address, data and lane mask, and holds them until `rspAck` pulses. A new request can be presented from the cycle after the acknowledge. The array sits inside the block as a register array with a synchronous read port, so a read's data appears together with its acknowledge.

Top module: `rmw_lane_mem`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises with no request, `rspAck` is low.
- R2: A read returns the whole 32-bit word stored at `reqAddr` on `rspRdata`, with `rspAck` high in the cycle after the accepting edge, whatever the value of `reqBe`.
- R3: A write with `reqBe` = 4'b1111 stores `reqWdata` with no preceding read, and acknowledges in the cycle after the accepting edge.
- R4: In a partial write, bit i of `reqBe` enables data bits [8i+7:8i]. Enabled lanes take the new data, and the other lanes keep their stored bytes. The address, data and mask captured at the accepting edge are the ones used, even if the inputs change afterwards.
- R5: A partial write (mask neither 0 nor all ones) acknowledges two cycles after the accepting edge, one cycle later than a full-word write.
- R6: A write with `reqBe` = 4'b0000 acknowledges in the cycle after the accepting edge and leaves the memory unchanged.
- R7: No request is accepted while a read-merge-write is in flight, nor at the edge where `rspAck` is high. A request still held there produces no second acknowledge.
- R8: A read issued right after a partial write to the same address returns the merged word.
- R9: When `reqWr` and `reqRd` are both high, the request is handled as a write.
- R10: `rspAck` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqRd | input | 1 | Read request, held until acknowledge |
| reqWr | input | 1 | Write request, held until acknowledge |
| reqAddr | input | 8 | Word address |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte-lane enables; bit i covers data bits [8i+7:8i] |
| rspRdata | output | 32 | Read data, valid with the acknowledge of a read |
| rspAck | output | 1 | One-cycle completion pulse |

## Verification
The bench mixes random reads and writes with a randomly drawn lane mask, and gives the all-ones and all-zeros masks extra weight. It checks every acknowledge latency and every read word against a model in the bench.

Directed cases cover the following, each with the symptom it catches:
- Inputs are changed while the merge is in flight. A design that merged with live inputs instead of the captured ones would corrupt a second address or write the wrong lanes.
- A request is held through its acknowledge. A missing guard would show up as a second acknowledge.
- A zero-mask write is followed by a readback. A design that wrote the raw data would change the word.
- A read follows a merge straight away. A design that skipped the write-back, or swapped the lane order, would return stale or shuffled bytes.

// File: rtl/rmw_lane_pkg.sv
package rmw_lane_pkg;
  // Strobes from the sequencer to the datapath for one cycle.
  typedef struct packed {
    logic capture; // latch address, data and mask of an accepted partial write
    logic memRd;   // load rdWord from the array
    logic memWr;   // write a full word into the array
    logic useHeld; // address and data come from the captured request, merged
  } memStrobes_t;

  typedef enum logic [0:0] {
    ST_IDLE  = 1'b0,
    ST_MERGE = 1'b1
  } seqState_t;
endpackage

// File: rtl/rmw_lane_ctrl.sv
module rmw_lane_ctrl
  import rmw_lane_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqRd,
  input  logic             reqWr,
  input  logic [LANES-1:0] reqBe,
  output memStrobes_t      strb,
  output logic             rspAck
);

  seqState_t state, stateNext;
  logic      ackNext;
  logic      accept;
  logic      beFull, beNone;

  assign accept = (state == ST_IDLE) && !rspAck;
  assign beFull = &reqBe;
  assign beNone = ~|reqBe;

  always_comb begin
    stateNext = state;
    ackNext   = 1'b0;
    strb      = '0;
    unique case (state)
      ST_IDLE: begin
        if (accept && reqWr) begin
          if (beFull) begin
            strb.memWr = 1'b1;
            ackNext    = 1'b1;
          end else if (beNone) begin
            ackNext    = 1'b1;
          end else begin
            strb.capture = 1'b1;
            strb.memRd   = 1'b1;
            stateNext    = ST_MERGE;
          end
        end else if (accept && reqRd) begin
          strb.memRd = 1'b1;
          ackNext    = 1'b1;
        end
      end
      ST_MERGE: begin
        strb.memWr   = 1'b1;
        strb.useHeld = 1'b1;
        ackNext      = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      rspAck <= 1'b0;
    end else begin
      state  <= stateNext;
      rspAck <= ackNext;
    end
  end

  // R10: the acknowledge never lasts two cycles
  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rstN)
    rspAck |=> !rspAck);

  // R5: the merge cycle always finishes with an acknowledge and returns to idle
  a_r5_merge_acks: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MERGE) |=> (rspAck && state == ST_IDLE));

  // R3: an accepted full-mask write acknowledges after one edge without a merge
  a_r3_full_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rspAck && reqWr && beFull) |=> (rspAck && state == ST_IDLE));

  // R2: an accepted read acknowledges after one edge
  a_r2_read_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !rspAck && !reqWr && reqRd) |=> rspAck);

  // R7: no acknowledge is visible while a merge is still pending
  a_r7_busy_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_MERGE) |-> !rspAck);

endmodule

// File: rtl/rmw_lane_dpath.sv
module rmw_lane_dpath
  import rmw_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobes_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic [DATA_W-1:0] rdWord
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] memArr [DEPTH];
  logic [ADDR_W-1:0] heldAddr;
  logic [DATA_W-1:0] heldData;
  logic [LANES-1:0]  heldBe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] wrWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldData <= '0;
      heldBe   <= '0;
    end else if (strb.capture) begin
      heldAddr <= reqAddr;
      heldData <= reqWdata;
      heldBe   <= reqBe;
    end
  end

  assign memAddr = strb.useHeld ? heldAddr : reqAddr;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign mergedWord[8*lane +: 8] = heldBe[lane] ? heldData[8*lane +: 8]
                                                  : rdWord[8*lane +: 8];
  end

  assign wrWord = strb.useHeld ? mergedWord : reqWdata;

  always_ff @(posedge clk) begin
    if (strb.memWr) memArr[memAddr] <= wrWord;
    if (strb.memRd) rdWord <= memArr[memAddr];
  end

  // R4: a merge write follows directly on the capture of its request
  a_r4_merge_after_capture: assert property (@(posedge clk) disable iff (!rstN)
    strb.useHeld |-> $past(strb.capture));

  // R7: a capture is never issued in the cycle that performs a merge write
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    strb.useHeld |-> !strb.capture);

endmodule

// File: rtl/rmw_lane_mem.sv
module rmw_lane_mem
  import rmw_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  localparam int LANES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRd,
  input  logic              reqWr,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspAck
);

  memStrobes_t strb;

  rmw_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .reqRd  (reqRd),
    .reqWr  (reqWr),
    .reqBe  (reqBe),
    .strb   (strb),
    .rspAck (rspAck)
  );

  rmw_lane_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqBe    (reqBe),
    .rdWord   (rspRdata)
  );

endmodule

// File: tb/rmw_lane_mem_bench.sv
module rmw_lane_mem_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqRd = 1'b0;
  logic        reqWr = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic [31:0] rspRdata;
  logic        rspAck;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [31:0] model [256];

  always #5 clk = ~clk;

  rmw_lane_mem u_rmw_lane_mem (
    .clk(clk), .rstN(rstN), .reqRd(reqRd), .reqWr(reqWr), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqBe(reqBe), .rspRdata(rspRdata), .rspAck(rspAck)
  );

  function automatic logic [31:0] mergeWord(logic [31:0] old, logic [31:0] d, logic [3:0] be);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (be[i]) r[8*i +: 8] = d[8*i +: 8];
    return r;
  endfunction

  function automatic int latencyOf(logic [3:0] be);
    return (be == 4'hF || be == 4'h0) ? 1 : 2;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  // Waits at falling edges until the acknowledge is seen; returns edges counted.
  task automatic waitAck(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!rspAck && cyc < 8);
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be,
                         input bool_rd, input string tag);
    int cyc;
    @(negedge clk);
    reqWr = 1'b1; reqRd = bool_rd; reqAddr = a; reqWdata = d; reqBe = be;
    waitAck(cyc);
    reqWr = 1'b0; reqRd = 1'b0;
    model[a] = mergeWord(model[a], d, be);
    check(cyc == latencyOf(be), tag, cyc, latencyOf(be));
  endtask

  task automatic doRead(input logic [7:0] a, input logic [3:0] be, input string tag);
    int cyc;
    @(negedge clk);
    reqRd = 1'b1; reqAddr = a; reqBe = be; reqWdata = $urandom;
    waitAck(cyc);
    reqRd = 1'b0;
    check(cyc == 1, {tag, " latency"}, cyc, 1);
    check(rspAck && rspRdata == model[a], {tag, " data"}, rspRdata, model[a]);
  endtask

  initial begin
    int cyc;
    void'($urandom(32'h0BAD_5EED));
    repeat (3) @(negedge clk);
    check(rspAck == 1'b0, "R1 ack low in reset", rspAck, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rspAck == 1'b0, "R1 ack low after reset", rspAck, 0);

    // R3: fill every word with full-mask writes
    for (int i = 0; i < 256; i++) begin
      model[i] = 'x;
      doWrite(8'(i), {8'(i), 8'hA5, 8'(~i), 8'h3C}, 4'hF, 1'b0, "R3 full write");
    end

    // R4 R5: single lanes, lane order
    doWrite(8'h10, 32'h11223344, 4'b0001, 1'b0, "R5 lane0 write");
    doRead(8'h10, 4'h0, "R4 lane0 readback");
    doWrite(8'h11, 32'h55667788, 4'b1000, 1'b0, "R5 lane3 write");
    doRead(8'h11, 4'h1, "R4 lane3 readback");
    doWrite(8'h12, 32'hDEADBEEF, 4'b0110, 1'b0, "R5 middle lanes write");
    doRead(8'h12, 4'hF, "R4 middle lanes readback");

    // R8: read right after a merge
    doWrite(8'h20, 32'hCAFEF00D, 4'b1100, 1'b0, "R5 upper half write");
    doRead(8'h20, 4'h0, "R8 read after merge");

    // R6: zero mask changes nothing
    doWrite(8'h30, 32'hFFFFFFFF, 4'b0000, 1'b0, "R6 zero mask latency");
    doRead(8'h30, 4'h0, "R6 zero mask unchanged");

    // R9: both strobes high is a write
    doWrite(8'h31, 32'h0F0F0F0F, 4'hF, 1'b1, "R9 both strobes latency");
    doRead(8'h31, 4'h0, "R9 both strobes readback");

    // R7 R10: request held through the acknowledge edge gives no second ack
    @(negedge clk);
    reqWr = 1'b1; reqAddr = 8'h40; reqWdata = 32'h12345678; reqBe = 4'hF;
    waitAck(cyc);
    model[8'h40] = 32'h12345678;
    @(negedge clk);
    check(rspAck == 1'b0, "R7 R10 no second ack while held", rspAck, 0);
    reqWr = 1'b0;
    doRead(8'h40, 4'h0, "R7 held write readback");

    // R4 R7: inputs change during the merge cycle; captured values are used
    @(negedge clk);
    reqWr = 1'b1; reqAddr = 8'h50; reqWdata = 32'hAABBCCDD; reqBe = 4'b0010;
    @(negedge clk);
    check(rspAck == 1'b0, "R7 no ack during merge", rspAck, 0);
    reqAddr = 8'h51; reqWdata = 32'h99999999; reqBe = 4'hF;
    @(negedge clk);
    check(rspAck == 1'b1, "R5 ack after merge", rspAck, 1);
    reqWr = 1'b0;
    model[8'h50] = mergeWord(model[8'h50], 32'hAABBCCDD, 4'b0010);
    doRead(8'h50, 4'h0, "R4 captured data merged");
    doRead(8'h51, 4'h0, "R7 other address untouched");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [7:0]  a  = 8'($urandom_range(0, 255));
      logic [31:0] d  = $urandom;
      logic [3:0]  be = 4'($urandom);
      int sel = $urandom_range(0, 9);
      if (sel == 0) be = 4'hF;
      if (sel == 1) be = 4'h0;
      if ($urandom_range(0, 1) == 0) doWrite(a, d, be, 1'b0, "R4 R5 random write");
      else doRead(a, be, "R2 random read");
    end

    for (int i = 0; i < 256; i++) doRead(8'(i), 4'($urandom), "R2 final sweep");
    finishRun();
  end

endmodule